// File: doc/BRIEF.md
# Serial Flash Main-Array Read Responder

This block is the device side of a serial flash interface for the read path only. The host lowers the chip-select, then clocks in an 8-bit command code, a 24-bit location and 32 filler bits. After that, each further serial clock pulse shifts one bit of array data out, most significant bit first. Data continues for as long as the host keeps clocking. The array itself sits outside the block. The block reaches it through a synchronous read port: it raises a one-cycle fetch strobe with a page index and a byte index, and the byte comes back on the next system clock. Each page holds 264 bytes. The number of pages is a parameter.

Two read flavours are decoded:
- **Sweep read** carries on past the end of a page into the next page. After the last page it returns to page 0.
- **Page-locked read** stays inside one page and loops back to byte 0 of that same page.

Serial pins are sampled in the system clock domain. The serial clock idles low. Input bits are taken on its rising edge, and output bits change on its falling edge. Timing requirements on the host:
- The serial clock's high and low phases must each last at least two system clocks.
- Chip-select must fall at least one system clock before the first rising serial edge.

The output enable stands in for a tri-state pad control.

Controller states:
- IDLE (deselected)
- OPCODE (collect 8 bits)
- ADDR (collect 24 bits)
- DUMMY (collect 32 filler bits while the first byte is fetched)
- DATA (drive bits out)
- IGNORE (command not recognised; stay silent)

Transitions:
- IDLE→OPCODE when chip-select is low.
- OPCODE→ADDR on the 8th rising edge if the code is known. OPCODE→IGNORE on that edge otherwise.
- ADDR→DUMMY on the 24th rising edge.
- DUMMY→DATA on the 32nd rising edge.
- Any state→IDLE whenever chip-select is high.

Top module: `sflash_rd_resp`

## Requirements
- R1: Command codes 0x68 and 0xE8 start a sweep read; 0x52 and 0xD2 start a page-locked read.
- R2: Of the 24 location bits (sent MSB first), bits 23:20 are ignored, bits 19:9 give the page and bits 8:0 give the starting byte; the first byte sent is the array byte at that location.
- R3: Exactly 32 filler bits follow the location. The output enable stays low through all 64 command bits. The MSB of the first byte appears after the falling serial edge that follows the 64th rising edge.
- R4: Input bits are taken on rising serial edges; the data output changes only after falling serial edges and holds through each high phase.
- R5: In a sweep read, the byte after byte 263 of page p is byte 0 of page p+1, with no gap in the bit stream.
- R6: In a sweep read, the byte after byte 263 of the last page is byte 0 of page 0, with no gap.
- R7: In a page-locked read, the byte after byte 263 is byte 0 of the same page.
- R8: Chip-select high ends a transfer at any point. The output enable is low from the system clock after chip-select is seen high, and the next selection decodes a fresh command.
- R9: For any other command code, the output enable stays low until chip-select goes high.
- R10: A starting byte value from 264 to 511 is treated as 263.
- R11: During and right after reset, the output enable and the fetch strobe are low.
- R12: Each fetch strobe lasts one system clock, and no fetched byte index exceeds 263.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip-select, active low |
| sck_i | input | 1 | Serial clock from host, idles low |
| si_i | input | 1 | Serial data in from host |
| so_o | output | 1 | Serial data out |
| so_oe_o | output | 1 | Output enable for the serial data out pad |
| rd_en_o | output | 1 | One-cycle array fetch strobe |
| rd_page_o | output | PAGE_W | Page index of the fetch |
| rd_byte_o | output | 9 | Byte index of the fetch, 0..263 |
| rd_data_i | input | 8 | Array byte, valid one clock after the strobe |

## Verification
On one falling serial edge, several things happen together:
- the byte in the holding register is loaded into the shifter;
- the location counter steps, possibly across a page wrap or an array wrap;
- a fetch for the following byte is launched.

The test cases provoke the wrap on that edge by starting reads at bytes 260 to 263, on ordinary pages and on the last page, in both read flavours. The check is that every byte leaving the pin, including the byte after the wrap, matches the array model. The bench also confirms that each bit stays steady across the high phase, so the extra load and step work never shifts the pin between falling edges.

// File: rtl/sflash_rd_pkg.sv
package sflash_rd_pkg;

    localparam int PAGE_BYTES = 264;
    localparam int BYTE_W     = 9;
    localparam int OPC_BITS   = 8;
    localparam int ADR_BITS   = 24;
    localparam int DMY_BITS   = 32;
    localparam int CNT_W      = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_IGNORE
    } rd_state_e;

    function automatic logic op_sweep(input logic [7:0] op);
        return (op == 8'h68) || (op == 8'hE8);
    endfunction

    function automatic logic op_paged(input logic [7:0] op);
        return (op == 8'h52) || (op == 8'hD2);
    endfunction

endpackage

// File: rtl/sflash_rd_edge.sv
module sflash_rd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    output logic rise_o,
    output logic fall_o
);
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_i;
    end

    assign rise_o = sck_i & ~sck_q;
    assign fall_o = ~sck_i & sck_q;
endmodule

// File: rtl/sflash_rd_addr.sv
module sflash_rd_addr
    import sflash_rd_pkg::*;
#(
    parameter int NUM_PAGES = 2048,
    localparam int PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [PAGE_W-1:0] load_page_i,
    input  logic [BYTE_W-1:0] load_byte_i,
    input  logic              sweep_i,
    input  logic              step_i,
    output logic [PAGE_W-1:0] page_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              fetch_o
);
    localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(PAGE_BYTES - 1);
    localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(NUM_PAGES - 1);

    logic [PAGE_W-1:0] page_q;
    logic [BYTE_W-1:0] byte_q;
    logic              fetch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q  <= '0;
            byte_q  <= '0;
            fetch_q <= 1'b0;
        end else begin
            fetch_q <= 1'b0;
            if (load_i) begin
                page_q  <= load_page_i;
                byte_q  <= (load_byte_i > LAST_BYTE) ? LAST_BYTE : load_byte_i;
                fetch_q <= 1'b1;
            end else if (step_i) begin
                fetch_q <= 1'b1;
                if (byte_q == LAST_BYTE) begin
                    byte_q <= '0;
                    if (sweep_i)
                        page_q <= (page_q == LAST_PAGE) ? '0 : page_q + 1'b1;
                end else begin
                    byte_q <= byte_q + 1'b1;
                end
            end
        end
    end

    assign page_o  = page_q;
    assign byte_o  = byte_q;
    assign fetch_o = fetch_q;
endmodule

// File: rtl/sflash_rd_shift.sv
module sflash_rd_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       fall_i,
    input  logic       cap_i,
    input  logic [7:0] data_i,
    output logic       so_o,
    output logic       load_o
);
    logic [2:0] idx_q;
    logic [7:0] hold_q;
    logic [7:0] sr_q;
    logic       so_q;

    assign load_o = en_i & fall_i & (idx_q == 3'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (cap_i) begin
            hold_q <= data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            sr_q  <= '0;
            so_q  <= 1'b0;
        end else if (!en_i) begin
            idx_q <= '0;
            sr_q  <= '0;
            so_q  <= 1'b0;
        end else if (fall_i) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == 3'd0) begin
                so_q <= hold_q[7];
                sr_q <= {hold_q[6:0], 1'b0};
            end else begin
                so_q <= sr_q[7];
                sr_q <= {sr_q[6:0], 1'b0};
            end
        end
    end

    assign so_o = so_q;
endmodule

// File: rtl/sflash_rd_resp.sv
module sflash_rd_resp
    import sflash_rd_pkg::*;
#(
    parameter int NUM_PAGES = 2048,
    localparam int PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic              si_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic              rd_en_o,
    output logic [PAGE_W-1:0] rd_page_o,
    output logic [BYTE_W-1:0] rd_byte_o,
    input  logic [7:0]        rd_data_i
);
    localparam logic [CNT_W-1:0] OPC_LAST = CNT_W'(OPC_BITS - 1);
    localparam logic [CNT_W-1:0] ADR_LAST = CNT_W'(ADR_BITS - 1);
    localparam logic [CNT_W-1:0] DMY_LAST = CNT_W'(DMY_BITS - 1);

    rd_state_e            state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [ADR_BITS-1:0]  in_sr_q;
    logic [ADR_BITS-1:0]  nxt_sr;
    logic                 sweep_q;
    logic                 cap_q;
    logic                 sck_rise, sck_fall;
    logic                 ld_addr, out_load, data_en, op_known;
    logic                 fetch;

    sflash_rd_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sck_i  (sck_i),
        .rise_o (sck_rise),
        .fall_o (sck_fall)
    );

    assign nxt_sr   = {in_sr_q[ADR_BITS-2:0], si_i};
    assign op_known = op_sweep(nxt_sr[7:0]) | op_paged(nxt_sr[7:0]);
    assign ld_addr  = (state_q == ST_ADDR) && sck_rise && (cnt_q == ADR_LAST) && !cs_n_i;
    assign data_en  = (state_q == ST_DATA);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_n_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_OPCODE;
                ST_OPCODE: if (sck_rise && cnt_q == OPC_LAST)
                               state_d = op_known ? ST_ADDR : ST_IGNORE;
                ST_ADDR:   if (sck_rise && cnt_q == ADR_LAST) state_d = ST_DUMMY;
                ST_DUMMY:  if (sck_rise && cnt_q == DMY_LAST) state_d = ST_DATA;
                ST_DATA:   state_d = ST_DATA;
                ST_IGNORE: state_d = ST_IGNORE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register and bookkeeping of the command phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            in_sr_q <= '0;
            sweep_q <= 1'b0;
            cap_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cap_q   <= fetch;
            if (state_d != state_q)
                cnt_q <= '0;
            else if (sck_rise)
                cnt_q <= cnt_q + 1'b1;
            if (sck_rise && (state_q == ST_OPCODE || state_q == ST_ADDR))
                in_sr_q <= nxt_sr;
            if (state_q == ST_OPCODE && sck_rise && cnt_q == OPC_LAST)
                sweep_q <= op_sweep(nxt_sr[7:0]);
        end
    end

    sflash_rd_addr #(.NUM_PAGES(NUM_PAGES)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (ld_addr),
        .load_page_i (nxt_sr[BYTE_W +: PAGE_W]),
        .load_byte_i (nxt_sr[BYTE_W-1:0]),
        .sweep_i     (sweep_q),
        .step_i      (out_load),
        .page_o      (rd_page_o),
        .byte_o      (rd_byte_o),
        .fetch_o     (fetch)
    );

    sflash_rd_shift u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (data_en),
        .fall_i (sck_fall),
        .cap_i  (cap_q),
        .data_i (rd_data_i),
        .so_o   (so_o),
        .load_o (out_load)
    );

    // outputs
    always_comb begin
        so_oe_o = data_en;
        rd_en_o = fetch;
    end
endmodule

// File: rtl/sflash_rd_resp_chk.sv
module sflash_rd_resp_chk
    import sflash_rd_pkg::*;
#(
    parameter int NUM_PAGES = 2048,
    localparam int PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_i,
    input logic              sck_i,
    input logic              so_o,
    input logic              so_oe_o,
    input logic              rd_en_o,
    input logic [PAGE_W-1:0] rd_page_o,
    input logic [BYTE_W-1:0] rd_byte_o,
    input logic              sweep_i
);
    localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(PAGE_BYTES - 1);
    localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(NUM_PAGES - 1);

    logic              sck_d;
    logic              prev_v;
    logic [PAGE_W-1:0] prev_page;
    logic [BYTE_W-1:0] prev_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d     <= 1'b0;
            prev_v    <= 1'b0;
            prev_page <= '0;
            prev_byte <= '0;
        end else begin
            sck_d <= sck_i;
            if (cs_n_i) begin
                prev_v <= 1'b0;
            end else if (rd_en_o) begin
                prev_v    <= 1'b1;
                prev_page <= rd_page_o;
                prev_byte <= rd_byte_o;
            end
        end
    end

    AST_OE_DROPS_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |=> !so_oe_o); // R8

    AST_FETCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> !rd_en_o); // R12

    AST_FETCH_BYTE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (rd_byte_o <= LAST_BYTE)); // R12

    AST_SO_HOLDS_OFF_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe_o && $past(so_oe_o) && !($past(sck_d) && !$past(sck_i))) |-> $stable(so_o)); // R4

    AST_STEP_WITHIN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && !cs_n_i && prev_v && prev_byte != LAST_BYTE)
            |-> (rd_byte_o == prev_byte + 1'b1 && rd_page_o == prev_page)); // R5

    AST_PAGED_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && !cs_n_i && prev_v && prev_byte == LAST_BYTE && !sweep_i)
            |-> (rd_byte_o == '0 && rd_page_o == prev_page)); // R7

    AST_SWEEP_NEXT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && !cs_n_i && prev_v && prev_byte == LAST_BYTE && sweep_i)
            |-> (rd_byte_o == '0 &&
                 rd_page_o == ((prev_page == LAST_PAGE) ? '0 : prev_page + 1'b1))); // R6
endmodule

bind sflash_rd_resp sflash_rd_resp_chk #(.NUM_PAGES(NUM_PAGES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_i    (cs_n_i),
    .sck_i     (sck_i),
    .so_o      (so_o),
    .so_oe_o   (so_oe_o),
    .rd_en_o   (rd_en_o),
    .rd_page_o (rd_page_o),
    .rd_byte_o (rd_byte_o),
    .sweep_i   (sweep_q)
);

// File: tb/sflash_rd_resp_tb.sv
module sflash_rd_resp_tb;
    localparam int NUM_PAGES = 2048;
    localparam int PAGE_W    = 11;
    localparam int NVEC      = 10;

    // {code, reserved, page, byte, byte count}
    localparam logic [39:0] VEC [NVEC] = '{
        {8'h68, 4'h0, 11'd5,    9'd0,   8'd6},
        {8'hE8, 4'h0, 11'd10,   9'd260, 8'd8},
        {8'h68, 4'h0, 11'd2047, 9'd262, 8'd4},
        {8'h52, 4'h0, 11'd3,    9'd261, 8'd6},
        {8'hD2, 4'h0, 11'd2047, 9'd263, 8'd3},
        {8'hE8, 4'hF, 11'd100,  9'd300, 8'd3},
        {8'h52, 4'h0, 11'd7,    9'd511, 8'd2},
        {8'h54, 4'h0, 11'd1,    9'd0,   8'd3},
        {8'hD2, 4'hA, 11'd1000, 9'd17,  8'd3},
        {8'hE8, 4'h0, 11'd0,    9'd0,   8'd4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic si = 1'b0;
    logic so, so_oe, rd_en;
    logic [PAGE_W-1:0] rd_page;
    logic [8:0] rd_byte;
    logic [7:0] rd_data = 8'h00;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    int pulse_err = 0;
    int fetches = 0;
    logic rd_en_d = 1'b0;

    always #2 clk = ~clk;

    sflash_rd_resp #(.NUM_PAGES(NUM_PAGES)) u_dut (
        .clk (clk), .rst_n (rst_n), .cs_n_i (cs_n), .sck_i (sck), .si_i (si),
        .so_o (so), .so_oe_o (so_oe), .rd_en_o (rd_en),
        .rd_page_o (rd_page), .rd_byte_o (rd_byte), .rd_data_i (rd_data)
    );

    function automatic logic [7:0] mem_val(input int p, input int b);
        int v;
        v = p * 29 + b * 13 + 90 + (p >> 3);
        return v[7:0];
    endfunction

    always @(posedge clk) begin
        if (rd_en) rd_data <= mem_val(int'(rd_page), int'(rd_byte));
        rd_en_d <= rd_en;
        if (rd_en) fetches <= fetches + 1;
        if (rd_en && rd_en_d) pulse_err <= pulse_err + 1;
    end

    function automatic string tag_of(input int i);
        case (i)
            0: return "R1";
            1: return "R5";
            2: return "R6";
            3: return "R7";
            4: return "R7";
            5: return "R10";
            6: return "R10";
            7: return "R9";
            8: return "R2";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic spi_bit(input logic b, output logic so_lo, output logic oe_lo,
                           output logic so_hi);
        sck = 1'b0;
        si  = b;
        repeat (4) @(negedge clk);
        so_lo = so;
        oe_lo = so_oe;
        sck = 1'b1;
        repeat (3) @(negedge clk);
        so_hi = so;
        @(negedge clk);
    endtask

    task automatic deselect(input string req);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        sck = 1'b0;
        repeat (2) @(negedge clk);
        chk(so_oe == 1'b0, req, "oe after deselect", int'(so_oe), 0);
    endtask

    task automatic run_vec(input logic [7:0] op, input logic [3:0] rsv,
                           input logic [10:0] pg, input logic [8:0] bt,
                           input int nb, input string tag);
        logic [63:0] cmd;
        logic lo, oe, hi;
        logic [7:0] got;
        bit oe_bad, stable_bad, oe_ok;
        bit valid, sweep;
        int p, b;
        valid = (op == 8'h68) || (op == 8'hE8) || (op == 8'h52) || (op == 8'hD2);
        sweep = (op == 8'h68) || (op == 8'hE8);
        p = int'(pg);
        b = (bt > 9'd263) ? 263 : int'(bt);
        cmd = {op, rsv, pg, bt, 32'hA5C3_0F96};
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        oe_bad = 1'b0;
        for (int i = 63; i >= 0; i--) begin
            spi_bit(cmd[i], lo, oe, hi);
            if (oe) oe_bad = 1'b1;
        end
        chk(!oe_bad, "R3", "oe during command bits", int'(oe_bad), 0);
        for (int k = 0; k < nb; k++) begin
            got = '0;
            oe_ok = 1'b1;
            stable_bad = 1'b0;
            for (int j = 7; j >= 0; j--) begin
                spi_bit(1'b0, lo, oe, hi);
                got[j] = lo;
                if (oe !== valid) oe_ok = 1'b0;
                if (valid && lo !== hi) stable_bad = 1'b1;
            end
            chk(oe_ok, valid ? tag : "R9", "oe level in data phase", int'(so_oe), int'(valid));
            if (valid) begin
                chk(got == mem_val(p, b), tag, "data byte", int'(got), int'(mem_val(p, b)));
                chk(!stable_bad, "R4", "so held through high phase", int'(stable_bad), 0);
                if (b == 263) begin
                    b = 0;
                    if (sweep) p = (p == NUM_PAGES - 1) ? 0 : p + 1;
                end else begin
                    b++;
                end
            end
        end
        deselect("R8");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic lo, oe, hi;
        logic [63:0] cmd;
        // R11: reset state
        repeat (3) @(negedge clk);
        chk(so_oe == 1'b0 && rd_en == 1'b0, "R11", "outputs in reset",
            int'({so_oe, rd_en}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(so_oe == 1'b0 && rd_en == 1'b0, "R11", "outputs after reset",
            int'({so_oe, rd_en}), 0);

        for (int v = 0; v < NVEC; v++) begin
            run_vec(VEC[v][39:32], VEC[v][31:28], VEC[v][27:17], VEC[v][16:8],
                    int'(VEC[v][7:0]), tag_of(v));
        end

        // R8: abort in the middle of the location bits
        cmd = {8'h68, 4'h0, 11'd4, 9'd0, 32'h0};
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 63; i >= 46; i--) spi_bit(cmd[i], lo, oe, hi);
        deselect("R8");

        // R8: abort in the middle of a data byte
        cmd = {8'hD2, 4'h0, 11'd9, 9'd0, 32'h0};
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 63; i >= 0; i--) spi_bit(cmd[i], lo, oe, hi);
        for (int i = 0; i < 12; i++) spi_bit(1'b0, lo, oe, hi);
        chk(oe == 1'b1, "R8", "oe before abort", int'(oe), 1);
        deselect("R8");

        // R8: fresh decode after both aborts
        run_vec(8'h68, 4'h0, 11'd12, 9'd5, 3, "R8");

        // R12: strobe width and range
        chk(pulse_err == 0, "R12", "strobe longer than one clock", pulse_err, 0);
        chk(fetches > 0, "R12", "fetches seen", fetches, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule